// File: doc/BRIEF.md
# PDM Amplifier Power-Down Sequencer

This controller decides when the digital core of a PDM-input class-D amplifier runs, idles or sleeps. It takes two indications from an upstream pattern detector, both already in the reference-clock domain. The first says that the in-band stop pattern is being received. The second pulses once for each ordinary, non-stop input word. From these it moves between four power states: ACTIVE, STANDBY, POWERDOWN and WAKING. It drives an output-stage enable, a mute and a one-cycle pulse that clears every setting chosen by in-band patterns.

An always-running reference clock feeds a watchdog that watches the PDM bit clock. The bit clock passes through a synchroniser, and its transitions are counted as activity. When no transition appears for a parameterised number of reference cycles, the clock is declared lost. Clock loss forces POWERDOWN from any state and clears the pattern settings. The block then sleeps until the bit clock returns and one non-stop word arrives. It then spends a fixed wake interval muted (0.5 ms by default at a 50 MHz reference) before it enables the output stage.

The power-on / undervoltage reset stops the output at once. At the first reference edge after that reset is released, the block captures the strapped gain and rate selection and holds it until the next reset.

Top module: `pdm_pwr_seq`

## Requirements
- R1: While `rst_n` is low, and immediately after it falls (asynchronously), `pwr_state` is POWERDOWN, `amp_en` is 0, `mute` is 1 and `cfg_clear` is 0. The state codes are ACTIVE=0, STANDBY=1, POWERDOWN=2, WAKING=3.
- R2: `strap_q` takes the value of `strap_in` at the first `clk_ref` rising edge after reset release. After that it stays unchanged until the next reset, even when `strap_in` changes or the clock is lost.
- R3: In ACTIVE, with the clock present, `stop_seen` high at a rising edge moves the block to STANDBY at that edge. `amp_en` falls and `mute` rises in the same cycle.
- R4: When no synchronised PDM clock transition occurs for LOSS_TICKS reference cycles, the block enters POWERDOWN from any state. Clock loss outranks every other input. The flag stays set until the next transition, and no loss is flagged sooner than LOSS_TICKS cycles after the last transition.
- R5: `cfg_clear` is high for exactly one reference cycle each time clock loss is newly flagged, and it coincides with entry to POWERDOWN.
- R6: In STANDBY or POWERDOWN, a `nonstop_seen` pulse while the clock is present moves the block to WAKING. While the clock is flagged lost the pulse is ignored. The return of the clock alone does not wake the block.
- R7: The block stays in WAKING, with `mute`=1 and `amp_en`=0, for exactly WAKE_TICKS reference cycles. It then enters ACTIVE with `amp_en`=1 and `mute`=0.
- R8: In WAKING, `stop_seen` aborts the wake to STANDBY, and clock loss aborts it to POWERDOWN.
- R9: `amp_en` is 1 only in ACTIVE, and `mute` is always its complement.
- R10: `nonstop_seen` in ACTIVE and `stop_seen` in POWERDOWN leave the state and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Active-low power-on / undervoltage reset, asynchronous assert |
| pdm_clk | input | 1 | Raw PDM bit clock, asynchronous to `clk_ref` |
| stop_seen | input | 1 | Stop pattern currently detected (level) |
| nonstop_seen | input | 1 | One-cycle pulse per non-stop input word |
| strap_in | input | STRAP_W | Strapped gain / rate selection |
| pwr_state | output | 2 | Current power state code |
| amp_en | output | 1 | Output-stage enable |
| mute | output | 1 | Output mute |
| cfg_clear | output | 1 | One-cycle pulse that resets pattern-chosen settings |
| strap_q | output | STRAP_W | Strap value captured after reset |

## Verification
A wrong state register shows at once on `pwr_state`, and it shows on `amp_en` and `mute` in the same cycle, because both are registered from the same next-state decision. An off-by-one in the wake counter therefore moves the rising edge of `amp_en` by one cycle, and the bench samples that edge cycle-exactly. A watchdog counter that expires too early or too late shows as POWERDOWN being entered outside a bounded window after the PDM clock stops. A missing or doubled clear pulse shows as a count of `cfg_clear` cycles other than one per loss. A strap latch that keeps tracking its input shows as `strap_q` following `strap_in` within one cycle.

// File: rtl/pdm_pwr_pkg.sv
package pdm_pwr_pkg;

   typedef enum logic [1:0] {
      PS_ACTIVE  = 2'd0,
      PS_STANDBY = 2'd1,
      PS_PWRDN   = 2'd2,
      PS_WAKING  = 2'd3
   } pwr_state_e;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/pdm_clk_watchdog.sv
module pdm_clk_watchdog #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LOSS_TICKS  = 64,
   parameter bit          BOTH_EDGES  = 1'b1
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic pdm_clk,
   output logic edge_seen,
   output logic clk_lost
);
   import pdm_pwr_pkg::*;

   localparam int unsigned CW = cnt_width(LOSS_TICKS);
   localparam logic [CW-1:0] LIMIT = CW'(LOSS_TICKS);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (LOSS_TICKS < 2) begin : g_bad_loss
      $error("LOSS_TICKS must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   lvl_q;
   logic                   sync_last;
   logic [CW-1:0]          idle_cnt;

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         lvl_q  <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pdm_clk};
         lvl_q  <= sync_q[SYNC_STAGES-1];
      end
   end

   assign sync_last = sync_q[SYNC_STAGES-1];

   if (BOTH_EDGES) begin : g_any_edge
      assign edge_seen = sync_last ^ lvl_q;
   end else begin : g_rise_edge
      assign edge_seen = sync_last & ~lvl_q;
   end

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         idle_cnt <= '0;
      end else if (edge_seen) begin
         idle_cnt <= '0;
      end else if (idle_cnt != LIMIT) begin
         idle_cnt <= idle_cnt + 1'b1;
      end
   end

   assign clk_lost = (idle_cnt == LIMIT);

   AST_EDGE_REARMS: assert property (@(posedge clk_ref) disable iff (!rst_n)
      edge_seen |=> !clk_lost);  // R4
   AST_LOSS_STICKY: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (clk_lost && !edge_seen) |=> clk_lost);  // R4

endmodule

// File: rtl/pdm_wake_timer.sv
module pdm_wake_timer #(
   parameter int unsigned WAKE_TICKS = 25000
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   import pdm_pwr_pkg::*;

   localparam int unsigned CW = cnt_width(WAKE_TICKS - 1);
   localparam logic [CW-1:0] LAST = CW'(WAKE_TICKS - 1);

   if (WAKE_TICKS < 2) begin : g_bad_wake
      $error("WAKE_TICKS must be at least 2");
   end

   logic [CW-1:0] wake_cnt;

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         wake_cnt <= '0;
      end else if (!run) begin
         wake_cnt <= '0;
      end else if (wake_cnt != LAST) begin
         wake_cnt <= wake_cnt + 1'b1;
      end
   end

   assign done = run && (wake_cnt == LAST);

   AST_WAKE_FROM_ZERO: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (!run) |=> (wake_cnt == '0));  // R7

endmodule

// File: rtl/pdm_strap_latch.sv
module pdm_strap_latch #(
   parameter int unsigned STRAP_W = 2
) (
   input  logic               clk_ref,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap_in,
   output logic [STRAP_W-1:0] strap_q
);
   if (STRAP_W < 1) begin : g_bad_strap
      $error("STRAP_W must be at least 1");
   end

   logic captured;

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         captured <= 1'b0;
         strap_q  <= '0;
      end else if (!captured) begin
         captured <= 1'b1;
         strap_q  <= strap_in;
      end
   end

   AST_STRAP_FROZEN: assert property (@(posedge clk_ref) disable iff (!rst_n)
      captured |=> $stable(strap_q));  // R2

endmodule

// File: rtl/pdm_pwr_seq.sv
module pdm_pwr_seq #(
   parameter int unsigned STRAP_W     = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LOSS_TICKS  = 64,
   parameter int unsigned WAKE_TICKS  = 25000,
   parameter bit          BOTH_EDGES  = 1'b1
) (
   input  logic               clk_ref,
   input  logic               rst_n,
   input  logic               pdm_clk,
   input  logic               stop_seen,
   input  logic               nonstop_seen,
   input  logic [STRAP_W-1:0] strap_in,
   output logic [1:0]         pwr_state,
   output logic               amp_en,
   output logic               mute,
   output logic               cfg_clear,
   output logic [STRAP_W-1:0] strap_q
);
   import pdm_pwr_pkg::*;

   pwr_state_e state_q, state_d;
   logic       clk_lost, edge_seen, lost_prev, wake_done;

   pdm_clk_watchdog #(
      .SYNC_STAGES (SYNC_STAGES),
      .LOSS_TICKS  (LOSS_TICKS),
      .BOTH_EDGES  (BOTH_EDGES)
   ) u_wdog (
      .clk_ref   (clk_ref),
      .rst_n     (rst_n),
      .pdm_clk   (pdm_clk),
      .edge_seen (edge_seen),
      .clk_lost  (clk_lost)
   );

   pdm_wake_timer #(
      .WAKE_TICKS (WAKE_TICKS)
   ) u_wake (
      .clk_ref (clk_ref),
      .rst_n   (rst_n),
      .run     (state_q == PS_WAKING),
      .done    (wake_done)
   );

   pdm_strap_latch #(
      .STRAP_W (STRAP_W)
   ) u_strap (
      .clk_ref  (clk_ref),
      .rst_n    (rst_n),
      .strap_in (strap_in),
      .strap_q  (strap_q)
   );

   always_comb begin
      state_d = state_q;
      if (clk_lost) begin
         state_d = PS_PWRDN;
      end else begin
         unique case (state_q)
            PS_ACTIVE:  if (stop_seen)    state_d = PS_STANDBY;
            PS_STANDBY: if (nonstop_seen) state_d = PS_WAKING;
            PS_PWRDN:   if (nonstop_seen) state_d = PS_WAKING;
            PS_WAKING: begin
               if (stop_seen)      state_d = PS_STANDBY;
               else if (wake_done) state_d = PS_ACTIVE;
            end
            default: state_d = PS_PWRDN;
         endcase
      end
   end

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= PS_PWRDN;
         amp_en    <= 1'b0;
         mute      <= 1'b1;
         cfg_clear <= 1'b0;
         lost_prev <= 1'b0;
      end else begin
         state_q   <= state_d;
         amp_en    <= (state_d == PS_ACTIVE);
         mute      <= (state_d != PS_ACTIVE);
         lost_prev <= clk_lost;
         cfg_clear <= clk_lost && !lost_prev;
      end
   end

   assign pwr_state = state_q;

   AST_STOP_EXITS_ACTIVE: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (state_q == PS_ACTIVE && stop_seen && !clk_lost) |=> (state_q == PS_STANDBY));  // R3
   AST_LOSS_FORCES_PDN: assert property (@(posedge clk_ref) disable iff (!rst_n)
      clk_lost |=> (state_q == PS_PWRDN));  // R4
   AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
      cfg_clear |=> !cfg_clear);  // R5
   AST_CLEAR_IN_PDN: assert property (@(posedge clk_ref) disable iff (!rst_n)
      cfg_clear |-> (state_q == PS_PWRDN));  // R5
   AST_LOST_BLOCKS_WAKE: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (state_q == PS_PWRDN && clk_lost) |=> (state_q == PS_PWRDN));  // R6
   AST_WAKE_MUTED: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (state_q == PS_WAKING) |-> (mute && !amp_en));  // R7
   AST_WAKE_ABORT_STOP: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (state_q == PS_WAKING && stop_seen && !clk_lost) |=> (state_q == PS_STANDBY));  // R8
   AST_EN_ONLY_ACTIVE: assert property (@(posedge clk_ref) disable iff (!rst_n)
      amp_en |-> (state_q == PS_ACTIVE && !mute));  // R9
   AST_ACTIVE_KEEPS: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (state_q == PS_ACTIVE && !stop_seen && !clk_lost) |=> (state_q == PS_ACTIVE));  // R10

endmodule

// File: tb/pdm_pwr_seq_bench.sv
module pdm_pwr_seq_bench;

   localparam int unsigned WAKE_T = 48;
   localparam int unsigned LOSS_T = 16;
   localparam int ST_ACT = 0, ST_SBY = 1, ST_PDN = 2, ST_WAK = 3;

   logic       clk_ref = 1'b0;
   logic       rst_n = 1'b0;
   logic       pdm_clk = 1'b0;
   logic       pdm_run = 1'b1;
   logic       stop_seen = 1'b0;
   logic       nonstop_seen = 1'b0;
   logic [1:0] strap_in = 2'b10;
   logic [1:0] pwr_state;
   logic       amp_en, mute, cfg_clear;
   logic [1:0] strap_q;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 1'b0;

   always #10 clk_ref = ~clk_ref;
   always #40 if (pdm_run) pdm_clk = ~pdm_clk;

   pdm_pwr_seq #(
      .STRAP_W    (2),
      .LOSS_TICKS (LOSS_T),
      .WAKE_TICKS (WAKE_T)
   ) u_pdm_pwr_seq (
      .clk_ref      (clk_ref),
      .rst_n        (rst_n),
      .pdm_clk      (pdm_clk),
      .stop_seen    (stop_seen),
      .nonstop_seen (nonstop_seen),
      .strap_in     (strap_in),
      .pwr_state    (pwr_state),
      .amp_en       (amp_en),
      .mute         (mute),
      .cfg_clear    (cfg_clear),
      .strap_q      (strap_q)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk_ref);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_outs(input string req, input int exp_state);
      chk(req, int'(pwr_state), exp_state);
      chk({req, "/R9 amp_en"}, int'(amp_en), (exp_state == ST_ACT) ? 1 : 0);
      chk({req, "/R9 mute"}, int'(mute), (exp_state == ST_ACT) ? 0 : 1);
   endtask

   task automatic pulse_nonstop();
      nonstop_seen = 1'b1;
      tick(1);
      nonstop_seen = 1'b0;
   endtask

   // stop the PDM clock and count clear pulses over a window
   task automatic lose_clock(input string req, input int early_state);
      int pulses = 0;
      pdm_run = 1'b0;
      for (int i = 0; i < 40; i++) begin
         tick(1);
         if (cfg_clear) pulses++;
         if (i == 7) chk({req, " R4 no early loss"}, int'(pwr_state), early_state);
      end
      chk({req, " R4 powerdown"}, int'(pwr_state), ST_PDN);
      chk({req, " R5 single clear"}, pulses, 1);
   endtask

   task automatic restart_clock();
      pdm_run = 1'b1;
      tick(12);
   endtask

   task automatic t_reset();
      tick(4);
      chk_outs("R1 in reset", ST_PDN);
      chk("R1 clear idle", int'(cfg_clear), 0);
      rst_n = 1'b1;
      tick(1);
      chk("R2 strap captured", int'(strap_q), 2);
   endtask

   task automatic t_startup_wake();
      pulse_nonstop();
      chk_outs("R6 wake from powerdown", ST_WAK);
      tick(WAKE_T - 1);
      chk_outs("R7 last waking cycle", ST_WAK);
      tick(1);
      chk_outs("R7 active after wake", ST_ACT);
   endtask

   task automatic t_strap_hold();
      strap_in = 2'b01;
      tick(3);
      chk("R2 strap held", int'(strap_q), 2);
   endtask

   task automatic t_nonstop_in_active();
      pulse_nonstop();
      tick(2);
      chk_outs("R10 nonstop ignored in active", ST_ACT);
   endtask

   task automatic t_stop();
      stop_seen = 1'b1;
      tick(1);
      chk_outs("R3 stop to standby", ST_SBY);
      tick(4);
      chk_outs("R3 standby held", ST_SBY);
      stop_seen = 1'b0;
   endtask

   task automatic t_wake_abort_stop();
      pulse_nonstop();
      chk_outs("R6 wake from standby", ST_WAK);
      tick(5);
      stop_seen = 1'b1;
      tick(1);
      chk_outs("R8 stop aborts wake", ST_SBY);
      stop_seen = 1'b0;
      tick(WAKE_T + 4);
      chk_outs("R8 stays standby", ST_SBY);
   endtask

   task automatic t_loss_in_standby();
      lose_clock("standby", ST_SBY);
      chk_outs("R4 outputs after loss", ST_PDN);
      chk("R2 strap survives loss", int'(strap_q), 2);
   endtask

   task automatic t_ignored_while_lost();
      pulse_nonstop();
      tick(3);
      chk_outs("R6 nonstop ignored while lost", ST_PDN);
      stop_seen = 1'b1;
      tick(3);
      chk_outs("R10 stop ignored in powerdown", ST_PDN);
      stop_seen = 1'b0;
   endtask

   task automatic t_return_then_loss_in_wake();
      restart_clock();
      chk_outs("R6 clock return alone no wake", ST_PDN);
      pulse_nonstop();
      chk_outs("R6 wake after clock return", ST_WAK);
      lose_clock("R8 waking", ST_WAK);
   endtask

   task automatic t_loss_from_active();
      restart_clock();
      pulse_nonstop();
      tick(WAKE_T + 2);
      chk_outs("R7 active again", ST_ACT);
      lose_clock("active", ST_ACT);
   endtask

   task automatic t_async_reset();
      restart_clock();
      pulse_nonstop();
      tick(WAKE_T + 2);
      chk_outs("R7 active before reset", ST_ACT);
      #3 rst_n = 1'b0;
      #1;
      chk_outs("R1 async reset", ST_PDN);
      strap_in = 2'b01;
      tick(2);
      rst_n = 1'b1;
      tick(1);
      chk("R2 strap recaptured", int'(strap_q), 1);
   endtask

   initial begin
      t_reset();
      t_startup_wake();
      t_strap_hold();
      t_nonstop_in_active();
      t_stop();
      t_wake_abort_stop();
      t_loss_in_standby();
      t_ignored_while_lost();
      t_return_then_loss_in_wake();
      t_loss_from_active();
      t_async_reset();
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk_ref);
      if (!done_flag) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule